// File: doc/BRIEF.md
# Translation Buffer Maintenance Port

This block holds the 64 entries of a software-managed address translation buffer and gives maintenance instructions access to them. In any cycle one operation can be issued. It can write the tag word or the data word of an indexed entry, read either word back, search the buffer for the entry that maps an effective address, or clear the valid flag of every entry. Each entry has a tag part and a data part. The tag part holds a page number, a page-size code, a valid flag and the process identifier that was current when the tag was written. The data part holds a real page number and execute and write permissions. Read permission is always granted.

Page sizes run from 1 KiB upward by factors of four, so size code c selects a page of 1024·4^c bytes. When a tag is written, the page number is aligned down to its page size. A search compares only the page-number bits above the page offset.

All results are registered. A read word, the identifier to reload after a tag read, and a search result each appear one clock edge after the operation is sampled. They are held until the next operation of the same kind. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `tlb_mgmt_port`

## Requirements
- R1: After reset, every entry is invalid with page numbers, identifiers and permissions zero. All outputs read zero.
- R2: The operation code `op_i` is 3 bits: 0 idle, 1 tag write, 2 data write, 3 tag read, 4 data read, 5 search, 6 invalidate all, 7 idle. Only the low 6 bits of `idx_i` select the entry.
- R3: A tag write takes the size code from `wdata_i[9:7]` and the page number from `wdata_i[31:10]`. It clears the low 2·code bits of that page number. It sets valid from `wdata_i[10]` and captures `pid_i` as the entry identifier.
- R4: A data write stores `wdata_i[31:10]` as the real page number, execute from bit 9 and write from bit 8. A data read returns that page number in bits [31:10], execute in bit 9, write in bit 8 and zero elsewhere.
- R5: A tag read returns the page number in bits [31:10], ORs the valid flag into bit 10, places the size code in bits [9:7] and leaves bits [6:0] zero. It drives the entry identifier on `pid_o` and raises `pid_load_o` for exactly the one cycle in which that result first appears.
- R6: A tag read of an entry whose size was never set by a tag write returns size code 1.
- R7: A search reports the lowest-index entry that meets three conditions. The entry is valid. Its identifier is zero or equals `pid_i`. Its page number equals `addr_i[31:10]` with the entry's page-offset bits cleared.
- R8: A search with no matching entry drives the found flag low and the index output to zero.
- R9: The search outputs change only on a search. The read word changes only on a tag or data read.
- R10: Invalidate-all clears the valid flag of all entries and leaves their other fields unchanged.
- R11: Results appear one edge after the operation is sampled. A read or search issued in the cycle after a write sees the written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| idx_i | input | IDX_IN_W (8) | Entry index, low 6 bits used |
| wdata_i | input | 32 | Tag or data word to write |
| addr_i | input | 32 | Effective address for search |
| pid_i | input | PID_W (8) | Current process identifier |
| rdata_o | output | 32 | Word returned by the last read |
| pid_o | output | PID_W (8) | Entry identifier from the last tag read |
| pid_load_o | output | 1 | One-cycle strobe to load `pid_o` |
| srch_idx_o | output | 6 | Index found by the last search |
| srch_hit_o | output | 1 | Last search found an entry |

## Verification
Every result of this block is due exactly one rising edge after its operation is sampled. This covers the read word, the identifier and its load strobe, and the search index with its found flag. The bench drives each operation just after a falling edge and checks that operation's results at the next falling edge, half a period after the edge that registered them. Because the next operation is issued in that same half cycle, the vectors that read or search straight after a write test that the new contents are visible in the following cycle. The directed tests then issue no operation and confirm that the read word and the search result stay unchanged. They also confirm that the load strobe drops after one cycle.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

  localparam int WORD_W    = 32;
  localparam int PG_SHIFT  = 10;
  localparam int EPN_W     = WORD_W - PG_SHIFT;
  localparam int SZC_W     = 3;
  localparam int SZS_W     = SZC_W + 1;
  localparam int VLD_BIT   = 10;
  localparam int SZ_LSB    = 7;
  localparam int EX_BIT    = 9;
  localparam int WE_BIT    = 8;
  localparam logic [SZC_W-1:0] SZC_FALLBACK = 3'd1;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WR_TAG  = 3'd1,
    OP_WR_DATA = 3'd2,
    OP_RD_TAG  = 3'd3,
    OP_RD_DATA = 3'd4,
    OP_SEARCH  = 3'd5,
    OP_INV_ALL = 3'd6,
    OP_RSVD    = 3'd7
  } tlb_op_e;

  // Tag half of an entry; szs[SZS_W-1] set means no size code was ever written.
  typedef struct packed {
    logic             vld;
    logic [SZS_W-1:0] szs;
    logic [EPN_W-1:0] epn;
  } tag_t;

  typedef struct packed {
    logic [EPN_W-1:0] rpn;
    logic             ex;
    logic             we;
  } data_t;

  // Keeps page-number bits above the page offset of a size code.
  function automatic logic [EPN_W-1:0] page_mask(input logic [SZC_W-1:0] code);
    logic [EPN_W-1:0] ones;
    ones = '1;
    return ones << {code, 1'b0};
  endfunction

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_tag,
  input  logic                           wr_data,
  input  logic                           inv_all,
  input  logic [IDX_W-1:0]               idx,
  input  logic [WORD_W-1:SZ_LSB]         wdata_hi,
  input  logic [PID_W-1:0]               pid,
  output tag_t  [ENTRIES-1:0]            tag_q,
  output logic  [ENTRIES-1:0][PID_W-1:0] epid_q,
  output data_t [ENTRIES-1:0]            dat_q
);

  logic [ENTRIES-1:0] vld_vec;

  // Decoded fields of the incoming tag word, shared by all entries.
  logic [SZC_W-1:0] new_szc;
  logic [EPN_W-1:0] new_epn;
  data_t            new_dat;

  always_comb begin
    new_szc     = wdata_hi[SZ_LSB+SZC_W-1:SZ_LSB];
    new_epn     = wdata_hi[WORD_W-1:PG_SHIFT] & page_mask(new_szc);
    new_dat.rpn = wdata_hi[WORD_W-1:PG_SHIFT];
    new_dat.ex  = wdata_hi[EX_BIT];
    new_dat.we  = wdata_hi[WE_BIT];
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gen_ent
    logic             sel;
    logic             tag_en;
    logic             dat_en;
    tag_t             tag_d;
    tag_t             tag_r;
    logic [PID_W-1:0] epid_d;
    logic [PID_W-1:0] epid_r;
    data_t            dat_r;

    assign sel    = (idx == IDX_W'(g));
    assign tag_en = (wr_tag && sel) || inv_all;
    assign dat_en = wr_data && sel;

    always_comb begin
      tag_d  = tag_r;
      epid_d = epid_r;
      if (wr_tag && sel) begin
        tag_d.vld = wdata_hi[VLD_BIT];
        tag_d.szs = {1'b0, new_szc};
        tag_d.epn = new_epn;
        epid_d    = pid;
      end else if (inv_all) begin
        tag_d.vld = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_r.vld <= 1'b0;
        tag_r.szs <= {1'b1, {SZC_W{1'b0}}};
        tag_r.epn <= '0;
        epid_r    <= '0;
      end else if (tag_en) begin
        tag_r  <= tag_d;
        epid_r <= epid_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_r <= '0;
      end else if (dat_en) begin
        dat_r <= new_dat;
      end
    end

    assign tag_q[g]  = tag_r;
    assign epid_q[g] = epid_r;
    assign dat_q[g]  = dat_r;
    assign vld_vec[g] = tag_r.vld;

    // R3: a valid entry always carries a written size and an aligned page number
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      tag_r.vld |-> (!tag_r.szs[SZC_W] &&
                     ((tag_r.epn & ~page_mask(tag_r.szs[SZC_W-1:0])) == '0)));
  end

  // R10: after invalidate-all no entry remains valid
  a_r10_inv_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_vec == '0));

  // R2: a tag write touches at most one entry's valid flag
  a_r2_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tag |=> ($countones(vld_vec ^ $past(vld_vec)) <= 1));

endmodule

// File: rtl/tlb_search_unit.sv
module tlb_search_unit
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  tag_t  [ENTRIES-1:0]            tag_q,
  input  logic  [ENTRIES-1:0][PID_W-1:0] epid_q,
  input  logic  [EPN_W-1:0]              addr_pn,
  input  logic  [PID_W-1:0]              pid,
  output logic                           hit,
  output logic  [IDX_W-1:0]              hit_idx
);

  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : gen_cmp
    logic pid_ok;
    logic pn_ok;
    assign pid_ok   = (epid_q[g] == '0) || (epid_q[g] == pid);
    assign pn_ok    = (addr_pn & page_mask(tag_q[g].szs[SZC_W-1:0])) == tag_q[g].epn;
    assign match[g] = tag_q[g].vld && pid_ok && pn_ok;
  end

  // Lowest index wins: scan downward so the last hit kept is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R7: a reported entry is valid and owned by the current or the global identifier
  a_r7_hit_owner: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (tag_q[hit_idx].vld &&
             (epid_q[hit_idx] == '0 || epid_q[hit_idx] == pid)));

  // R8: a miss leaves the index at zero
  a_r8_miss_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));

endmodule

// File: rtl/tlb_result_regs.sv
module tlb_result_regs
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_tag,
  input  logic               rd_data,
  input  logic               srch,
  input  tag_t               tag_sel,
  input  logic [PID_W-1:0]   epid_sel,
  input  data_t              dat_sel,
  input  logic               hit_c,
  input  logic [IDX_W-1:0]   idx_c,
  output logic [WORD_W-1:0]  rdata_o,
  output logic [PID_W-1:0]   pid_o,
  output logic               pid_load_o,
  output logic [IDX_W-1:0]   srch_idx_o,
  output logic               srch_hit_o
);

  logic [WORD_W-1:0] rdata_d;
  logic [PID_W-1:0]  pid_d;
  logic [SZC_W-1:0]  szc_out;
  logic              rd_en;

  assign rd_en = rd_tag || rd_data;

  always_comb begin
    szc_out = tag_sel.szs[SZC_W] ? SZC_FALLBACK : tag_sel.szs[SZC_W-1:0];
    rdata_d = '0;
    pid_d   = pid_o;
    if (rd_tag) begin
      rdata_d[WORD_W-1:PG_SHIFT]         = tag_sel.epn;
      rdata_d[VLD_BIT]                   = tag_sel.epn[0] | tag_sel.vld;
      rdata_d[SZ_LSB+SZC_W-1:SZ_LSB]     = szc_out;
      pid_d                              = epid_sel;
    end else begin
      rdata_d[WORD_W-1:PG_SHIFT]         = dat_sel.rpn;
      rdata_d[EX_BIT]                    = dat_sel.ex;
      rdata_d[WE_BIT]                    = dat_sel.we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      pid_o   <= '0;
    end else if (rd_en) begin
      rdata_o <= rdata_d;
      pid_o   <= pid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_load_o <= 1'b0;
    end else begin
      pid_load_o <= rd_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_hit_o <= 1'b0;
      srch_idx_o <= '0;
    end else if (srch) begin
      srch_hit_o <= hit_c;
      srch_idx_o <= idx_c;
    end
  end

  // R5: strobe follows a tag read by exactly one edge
  a_r5_pid_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tag |=> pid_load_o);
  a_r5_pid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_tag |=> !pid_load_o);

  // R9: search outputs hold between searches
  a_r9_srch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !srch |=> ($stable(srch_idx_o) && $stable(srch_hit_o)));

  // R9: read word holds between reads
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o));

  // R8: a registered miss never reports a nonzero index
  a_r8_miss_out: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_hit_o |-> (srch_idx_o == '0));

endmodule

// File: rtl/tlb_mgmt_port.sv
module tlb_mgmt_port
  import tlb_mgmt_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int PID_W    = 8,
  parameter int IDX_IN_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  op_i,
  input  logic [IDX_IN_W-1:0]         idx_i,
  input  logic [31:0]                 wdata_i,
  input  logic [31:0]                 addr_i,
  input  logic [PID_W-1:0]            pid_i,
  output logic [31:0]                 rdata_o,
  output logic [PID_W-1:0]            pid_o,
  output logic                        pid_load_o,
  output logic [$clog2(ENTRIES)-1:0]  srch_idx_o,
  output logic                        srch_hit_o
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic                           rst_ns;
  tlb_op_e                        op;
  logic                           wr_tag, wr_data, rd_tag, rd_data, srch, inv_all;
  logic [IDX_W-1:0]               idx;
  tag_t  [ENTRIES-1:0]            tag_q;
  logic  [ENTRIES-1:0][PID_W-1:0] epid_q;
  data_t [ENTRIES-1:0]            dat_q;
  logic                           hit_c;
  logic [IDX_W-1:0]               idx_c;
  logic                           unused_in;

  assign unused_in = ^{wdata_i[SZ_LSB-1:0], addr_i[PG_SHIFT-1:0], idx_i[IDX_IN_W-1:IDX_W]};

  tlb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    op      = tlb_op_e'(op_i);
    wr_tag  = (op == OP_WR_TAG);
    wr_data = (op == OP_WR_DATA);
    rd_tag  = (op == OP_RD_TAG);
    rd_data = (op == OP_RD_DATA);
    srch    = (op == OP_SEARCH);
    inv_all = (op == OP_INV_ALL);
    idx     = idx_i[IDX_W-1:0];
  end

  tlb_entry_store #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data),
    .inv_all  (inv_all),
    .idx      (idx),
    .wdata_hi (wdata_i[WORD_W-1:SZ_LSB]),
    .pid      (pid_i),
    .tag_q    (tag_q),
    .epid_q   (epid_q),
    .dat_q    (dat_q)
  );

  tlb_search_unit #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_search (
    .clk     (clk),
    .rst_n   (rst_ns),
    .tag_q   (tag_q),
    .epid_q  (epid_q),
    .addr_pn (addr_i[WORD_W-1:PG_SHIFT]),
    .pid     (pid_i),
    .hit     (hit_c),
    .hit_idx (idx_c)
  );

  tlb_result_regs #(.ENTRIES(ENTRIES), .PID_W(PID_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_ns),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .srch       (srch),
    .tag_sel    (tag_q[idx]),
    .epid_sel   (epid_q[idx]),
    .dat_sel    (dat_q[idx]),
    .hit_c      (hit_c),
    .idx_c      (idx_c),
    .rdata_o    (rdata_o),
    .pid_o      (pid_o),
    .pid_load_o (pid_load_o),
    .srch_idx_o (srch_idx_o),
    .srch_hit_o (srch_hit_o)
  );

endmodule

// File: tb/sim_tlb_mgmt_port.sv
`timescale 1ns/1ps
module sim_tlb_mgmt_port;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [7:0]  idx_i;
  logic [31:0] wdata_i;
  logic [31:0] addr_i;
  logic [7:0]  pid_i;
  logic [31:0] rdata_o;
  logic [7:0]  pid_o;
  logic        pid_load_o;
  logic [5:0]  srch_idx_o;
  logic        srch_hit_o;

  int vec_n;
  int miss_n;
  bit done;

  tlb_mgmt_port u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .wdata_i(wdata_i),
    .addr_i(addr_i), .pid_i(pid_i), .rdata_o(rdata_o), .pid_o(pid_o),
    .pid_load_o(pid_load_o), .srch_idx_o(srch_idx_o), .srch_hit_o(srch_hit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  idx;
    logic [31:0] wdata;
    logic [31:0] addr;
    logic [7:0]  pid;
    logic [1:0]  kind;   // 0 none, 1 read word, 2 search
    logic [31:0] ew;
    logic [7:0]  ep;
    logic        eh;
    logic [5:0]  ei;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 8'h03, 32'h12345500, 32'h0,        8'h05, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd3, 8'h03, 32'h0,        32'h0,        8'h77, 2'd1, 32'h12344500, 8'h05, 1'b0, 6'd0},
    '{3'd2, 8'h03, 32'hABCDE3FF, 32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd4, 8'h03, 32'h0,        32'h0,        8'h00, 2'd1, 32'hABCDE300, 8'h05, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h12347FFC, 8'h05, 2'd2, 32'h0,        8'h00, 1'b1, 6'd3},
    '{3'd5, 8'h00, 32'h0,        32'h12348000, 8'h05, 2'd2, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h12344000, 8'h06, 2'd2, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd1, 8'h01, 32'h12340600, 32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h12347FFC, 8'h05, 2'd2, 32'h0,        8'h00, 1'b1, 6'd1},
    '{3'd5, 8'h00, 32'h0,        32'h12347FFC, 8'h09, 2'd2, 32'h0,        8'h00, 1'b1, 6'd1},
    '{3'd3, 8'h01, 32'h0,        32'h0,        8'h00, 2'd1, 32'h12340600, 8'h00, 1'b0, 6'd0},
    '{3'd1, 8'h01, 32'h12340200, 32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h12347FFC, 8'h05, 2'd2, 32'h0,        8'h00, 1'b1, 6'd3},
    '{3'd1, 8'h7F, 32'hFFFFFF80, 32'h0,        8'h22, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd3, 8'h3F, 32'h0,        32'h0,        8'h00, 2'd1, 32'hFF000780, 8'h22, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'hFF123456, 8'h22, 2'd2, 32'h0,        8'h00, 1'b1, 6'd63},
    '{3'd3, 8'h05, 32'h0,        32'h0,        8'h00, 2'd1, 32'h00000080, 8'h00, 1'b0, 6'd0},
    '{3'd6, 8'h00, 32'h0,        32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h12347FFC, 8'h05, 2'd2, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd3, 8'h03, 32'h0,        32'h0,        8'h00, 2'd1, 32'h12344100, 8'h05, 1'b0, 6'd0},
    '{3'd1, 8'h40, 32'h00000C00, 32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd3, 8'h00, 32'h0,        32'h0,        8'h00, 2'd1, 32'h00000C00, 8'h00, 1'b0, 6'd0},
    '{3'd7, 8'h00, 32'hFFFFFFFF, 32'h0,        8'h00, 2'd0, 32'h0,        8'h00, 1'b0, 6'd0},
    '{3'd5, 8'h00, 32'h0,        32'h00000FFF, 8'h03, 2'd2, 32'h0,        8'h00, 1'b1, 6'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] idx, input logic [31:0] wd,
                       input logic [31:0] ad, input logic [7:0] pid);
    op_i = op; idx_i = idx; wdata_i = wd; addr_i = ad; pid_i = pid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss_n++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
      $finish;
    end
  end

  initial begin
    vec_n = 0; miss_n = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(3'd0, 8'h0, 32'h0, 32'h0, 8'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 rdata",    rdata_o, 32'h0);
    chk("R1 pid",      32'(pid_o), 32'h0);
    chk("R1 pid_load", 32'(pid_load_o), 32'h0);
    chk("R1 hit",      32'(srch_hit_o), 32'h0);
    chk("R1 idx",      32'(srch_idx_o), 32'h0);

    // Table walk: R2..R8, R10, R11 (each result sampled one edge after its op)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.op, v.idx, v.wdata, v.addr, v.pid);
      @(negedge clk);
      if (v.kind == 2'd1) begin
        chk("R4/R5/R6/R11 read word", rdata_o, v.ew);
        chk("R5 pid_load", 32'(pid_load_o), 32'(v.op == 3'd3));
        if (v.op == 3'd3) chk("R5 pid", 32'(pid_o), 32'(v.ep));
      end else if (v.kind == 2'd2) begin
        chk("R7/R8 hit", 32'(srch_hit_o), 32'(v.eh));
        chk("R7/R8 idx", 32'(srch_idx_o), 32'(v.ei));
      end
    end

    // R5: strobe lasts one cycle; R9: outputs held while idle
    drive(3'd3, 8'h00, 32'h0, 32'h0, 8'h00);
    @(negedge clk);
    chk("R5 strobe high", 32'(pid_load_o), 32'h1);
    drive(3'd0, 8'h00, 32'h0, 32'h0, 8'h00);
    @(negedge clk);
    chk("R5 strobe low", 32'(pid_load_o), 32'h0);
    chk("R9 rdata held", rdata_o, 32'h00000C00);
    chk("R9 hit held",   32'(srch_hit_o), 32'h1);

    // R9: a write does not move the search result; R3 valid clear, then re-search misses
    drive(3'd1, 8'h00, 32'h0, 32'h0, 8'h00);
    @(negedge clk);
    chk("R9 hit kept after write", 32'(srch_hit_o), 32'h1);
    chk("R9 rdata kept after write", rdata_o, 32'h00000C00);
    drive(3'd5, 8'h00, 32'h0, 32'h00000FFF, 8'h03);
    @(negedge clk);
    chk("R3 cleared entry misses", 32'(srch_hit_o), 32'h0);
    chk("R8 miss idx", 32'(srch_idx_o), 32'h0);
    drive(3'd0, 8'h00, 32'h0, 32'h0, 8'h00);
    @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

endmodule